// File: doc/BRIEF.md
# Serial Flash Host Transfer Engine

This block is a register-driven SPI host for serial flash devices. It moves up to 64 bytes in one full-duplex transfer on a single data lane. The bytes come from a buffer of sixteen 32-bit words. Software loads the outgoing bytes into the buffer and programs the length, the SCK shape and the polarities. It then decides whether chip select stays asserted once the transfer ends, clears the done flag and writes the start bit. The engine shifts the buffer out on MOSI. It captures MISO into the same buffer positions, so received bytes replace sent bytes in place. When the last bit has moved it raises the done flag.

Several 64-byte chunks can form one flash command. Software keeps chip select asserted between chunks with the hold bit and clears the bit for the final chunk. SCK runs from a divider, and the length of the active phase of each bit period is programmed separately. The engine works in clock phase 0 only. MISO is sampled during the active phase, and MOSI changes on the trailing edge. A soft reset aborts a transfer in progress.

Top module: `sfh_host`

## Requirements
- R1: After reset, chip select is inactive (high with the default active-low polarity), SCK is low, MOSI is low, and the command (0x00) and status (0x30) registers read 0.
- R2: Writing a word with bit 18 set to offset 0x00 starts a transfer. Bit 18 of offset 0x00 reads 1 while the transfer runs and 0 otherwise.
- R3: Bits 25:17 of offset 0x20 hold the transfer length in bits minus one. A transfer produces exactly that many plus one SCK leading edges, for whole-byte lengths from 8 to 512 bits.
- R4: Transfer byte k is bits 8*(k mod 4)+7 down to 8*(k mod 4) of the buffer word at offset 0x40+4*(k div 4). Each byte is sent most significant bit first.
- R5: When bit 0 of offset 0x1c is set, each received byte overwrites the buffer byte it was shifted against. When the bit is clear, the buffer keeps its contents.
- R6: When bit 27 of offset 0x1c is clear, MOSI stays low for the whole transfer.
- R7: Bit 4 of offset 0x30 becomes 1 after the last bit. A write to offset 0x30 with bit 4 at 0 clears it, and a write with bit 4 at 1 leaves it as it is.
- R8: Chip select stays asserted and stable for the whole transfer. It is released at the end unless bit 30 of offset 0x2c was set at the start, in which case it stays asserted until a later transfer ends with that bit clear.
- R9: When bit 23 of offset 0x2c is set, chip select is active-high.
- R10: The clock register at offset 0x18 holds the divider in bits 17:12, the active count in bits 11:6 and a low count in bits 5:0, and reads back only those bits. With active count below the divider, one bit period lasts divider+1 clock cycles, of which active count+1 are in the active SCK phase.
- R11: When bit 7 of offset 0x1c or bit 29 of offset 0x2c is set, SCK idles high and its leading edge is falling. MOSI changes only when SCK returns to its idle level.
- R12: A start write during a transfer is ignored, and the running transfer keeps its length.
- R13: Writing a word with bit 31 set to offset 0x30 aborts any transfer. Afterwards busy and done read 0, chip select is released, SCK is idle, and bit 31 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte offset (word aligned) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Data to the flash |
| spi_miso | input | 1 | Data from the flash |
| spi_cs | output | 1 | Chip select, polarity programmable |

## Verification
Most internal faults in this engine show at the pins within one bit period. The faults covered here are a wrong bit index, a slipped byte lane, and a capture at the wrong phase. They show as a wrong byte on MOSI at the flash model, or as a wrong byte read back from the buffer after the first byte boundary. A length latch or end-of-transfer fault changes the count of SCK leading edges. A stuck busy state shows as a done flag that never rises. A chip-select hold fault is visible on the pin in the first cycle after the transfer ends. An SCK counter fault appears in the measured width of the very first active phase.

// File: rtl/sfh_pkg.sv
package sfh_pkg;

    localparam int unsigned REG_AW = 7;
    localparam int unsigned DW     = 32;
    localparam int unsigned CLK_FW = 6;

    localparam logic [REG_AW-1:0] OFS_CMD   = 7'h00;
    localparam logic [REG_AW-1:0] OFS_CTRL  = 7'h08;
    localparam logic [REG_AW-1:0] OFS_CLK   = 7'h18;
    localparam logic [REG_AW-1:0] OFS_USER  = 7'h1c;
    localparam logic [REG_AW-1:0] OFS_USER1 = 7'h20;
    localparam logic [REG_AW-1:0] OFS_USER4 = 7'h2c;
    localparam logic [REG_AW-1:0] OFS_STAT  = 7'h30;
    localparam logic [REG_AW-1:0] OFS_BUF   = 7'h40;

    localparam int unsigned CMD_GO_BIT     = 18;
    localparam int unsigned USR_DIN_BIT    = 0;
    localparam int unsigned USR_CPOL_BIT   = 7;
    localparam int unsigned USR_DOUT_BIT   = 27;
    localparam int unsigned LEN_LSB        = 17;
    localparam int unsigned U4_CSHI_BIT    = 23;
    localparam int unsigned U4_IDLEHI_BIT  = 29;
    localparam int unsigned U4_HOLD_BIT    = 30;
    localparam int unsigned STAT_DONE_BIT  = 4;
    localparam int unsigned STAT_MODE_BIT  = 30;
    localparam int unsigned STAT_RST_BIT   = 31;

    typedef struct packed {
        logic [CLK_FW-1:0] div;
        logic [CLK_FW-1:0] act;
        logic [CLK_FW-1:0] low;
    } sck_cfg_t;

    typedef enum logic {ENG_IDLE, ENG_SHIFT} eng_state_t;

    // Position inside a 32-bit word of the bit sent as transfer bit b
    // (byte lane from b[4:3], MSB first inside the byte).
    function automatic logic [4:0] bit_pos(input logic [4:0] b);
        return {b[4:3], ~b[2:0]};
    endfunction

endpackage

// File: rtl/sfh_sck_timer.sv
module sfh_sck_timer #(
    parameter int unsigned CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [CW-1:0] div,
    input  logic [CW-1:0] act,
    output logic          sck_act,
    output logic          sample_stb,
    output logic          bit_end_stb
);

    logic [CW-1:0] cnt_q;
    logic [CW:0]   sum;

    // The active phase is the tail of each bit period: act+1 cycles long.
    assign sum         = {1'b0, cnt_q} + {1'b0, act};
    assign sck_act     = run && (sum >= {1'b0, div});
    assign sample_stb  = run && (sum == {1'b0, div});
    assign bit_end_stb = run && (cnt_q == div);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == div) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sfh_shift_eng.sv
module sfh_shift_eng
    import sfh_pkg::*;
#(
    parameter int unsigned IDXW = 9,
    parameter int unsigned BSW  = IDXW - 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            srst,
    input  logic            start,
    input  logic [IDXW-1:0] last_idx,
    input  logic            hold_req,
    input  logic            sample_stb,
    input  logic            bit_end_stb,
    input  logic            miso,
    output logic            busy,
    output logic [IDXW-1:0] bit_idx,
    output logic            cs_act,
    output logic            cs_hold,
    output logic            done_pulse,
    output logic            byte_we,
    output logic [BSW-1:0]  byte_sel,
    output logic [7:0]      byte_data
);

    eng_state_t      st_q;
    logic [IDXW-1:0] idx_q;
    logic [IDXW-1:0] last_q;
    logic [7:0]      rx_q;
    logic [7:0]      rx_next;
    logic            hold_q;
    logic            cs_q;
    logic            shifting;

    assign shifting = (st_q == ENG_SHIFT);
    assign rx_next  = sample_stb ? {rx_q[6:0], miso} : rx_q;

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            st_q   <= ENG_IDLE;
            idx_q  <= '0;
            last_q <= '0;
            rx_q   <= '0;
            hold_q <= 1'b0;
            cs_q   <= 1'b0;
        end else begin
            case (st_q)
                ENG_IDLE: begin
                    if (start) begin
                        st_q   <= ENG_SHIFT;
                        idx_q  <= '0;
                        last_q <= last_idx;
                        hold_q <= hold_req;
                        cs_q   <= 1'b1;
                        rx_q   <= '0;
                    end
                end
                ENG_SHIFT: begin
                    rx_q <= rx_next;
                    if (bit_end_stb) begin
                        if (idx_q == last_q) begin
                            st_q <= ENG_IDLE;
                            cs_q <= hold_q;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                default: st_q <= ENG_IDLE;
            endcase
        end
    end

    assign busy       = shifting;
    assign bit_idx    = idx_q;
    assign cs_act     = cs_q;
    assign cs_hold    = hold_q;
    assign done_pulse = shifting && bit_end_stb && (idx_q == last_q);
    assign byte_we    = shifting && bit_end_stb && (idx_q[2:0] == 3'b111);
    assign byte_sel   = idx_q[IDXW-1:3];
    assign byte_data  = rx_next;

endmodule

// File: rtl/sfh_buf.sv
module sfh_buf
    import sfh_pkg::*;
#(
    parameter int unsigned WORDS = 16,
    parameter int unsigned WIW   = $clog2(WORDS),
    parameter int unsigned BSW   = WIW + 2,
    parameter int unsigned IDXW  = BSW + 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_we,
    input  logic [WIW-1:0]  bus_widx,
    input  logic [DW-1:0]   bus_wdata,
    input  logic [WIW-1:0]  rd_widx,
    output logic [DW-1:0]   rd_data,
    input  logic            byte_we,
    input  logic [BSW-1:0]  byte_sel,
    input  logic [7:0]      byte_data,
    input  logic [IDXW-1:0] bit_idx,
    output logic            bit_out
);

    logic [DW-1:0] mem [WORDS];

    // Engine byte writes come last, so they win over a bus write.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < int'(WORDS); w++) begin
                mem[w] <= '0;
            end
        end else begin
            if (bus_we) begin
                mem[bus_widx] <= bus_wdata;
            end
            if (byte_we) begin
                mem[byte_sel[BSW-1:2]][{byte_sel[1:0], 3'b000} +: 8] <= byte_data;
            end
        end
    end

    assign rd_data = mem[rd_widx];
    assign bit_out = mem[bit_idx[IDXW-1:5]][bit_pos(bit_idx[4:0])];

endmodule

// File: rtl/sfh_host.sv
module sfh_host
    import sfh_pkg::*;
#(
    parameter int unsigned BUF_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs
);

    localparam int unsigned WIW  = $clog2(BUF_WORDS);
    localparam int unsigned BSW  = WIW + 2;
    localparam int unsigned IDXW = BSW + 3;

    logic [DW-1:0] ctrl_q;
    sck_cfg_t      clk_cfg_q;
    logic [DW-1:0] user_q;
    logic [DW-1:0] user1_q;
    logic [DW-1:0] user4_q;
    logic          mode_q;
    logic          done_q;

    logic            busy;
    logic            cs_act;
    logic            cs_hold;
    logic            done_pulse;
    logic            srst;
    logic            start_go;
    logic            wr_stat;
    logic            cpol;
    logic            sck_act;
    logic            sample_stb;
    logic            bit_end_stb;
    logic [IDXW-1:0] bit_idx;
    logic            eng_byte_we;
    logic [BSW-1:0]  byte_sel;
    logic [7:0]      byte_data;
    logic            buf_hit;
    logic [DW-1:0]   buf_rdata;
    logic            buf_bit;

    assign buf_hit  = (reg_addr >= OFS_BUF);
    assign wr_stat  = reg_wr && (reg_addr == OFS_STAT);
    assign srst     = wr_stat && reg_wdata[STAT_RST_BIT];
    assign start_go = reg_wr && (reg_addr == OFS_CMD) && reg_wdata[CMD_GO_BIT]
                      && !busy && !srst;
    assign cpol     = user_q[USR_CPOL_BIT] | user4_q[U4_IDLEHI_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            clk_cfg_q <= '0;
            user_q    <= '0;
            user1_q   <= '0;
            user4_q   <= '0;
            mode_q    <= 1'b0;
        end else if (reg_wr) begin
            case (reg_addr)
                OFS_CTRL:  ctrl_q    <= reg_wdata;
                OFS_CLK:   clk_cfg_q <= reg_wdata[$bits(sck_cfg_t)-1:0];
                OFS_USER:  user_q    <= reg_wdata;
                OFS_USER1: user1_q   <= reg_wdata;
                OFS_USER4: user4_q   <= reg_wdata;
                OFS_STAT:  mode_q    <= reg_wdata[STAT_MODE_BIT];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            done_q <= 1'b0;
        end else if (done_pulse) begin
            done_q <= 1'b1;
        end else if (wr_stat && !reg_wdata[STAT_DONE_BIT]) begin
            done_q <= 1'b0;
        end
    end

    sfh_sck_timer #(.CW(CLK_FW)) u_sck (
        .clk         (clk),
        .rst         (rst),
        .run         (busy),
        .div         (clk_cfg_q.div),
        .act         (clk_cfg_q.act),
        .sck_act     (sck_act),
        .sample_stb  (sample_stb),
        .bit_end_stb (bit_end_stb)
    );

    sfh_shift_eng #(.IDXW(IDXW), .BSW(BSW)) u_eng (
        .clk         (clk),
        .rst         (rst),
        .srst        (srst),
        .start       (start_go),
        .last_idx    (user1_q[LEN_LSB +: IDXW]),
        .hold_req    (user4_q[U4_HOLD_BIT]),
        .sample_stb  (sample_stb),
        .bit_end_stb (bit_end_stb),
        .miso        (spi_miso),
        .busy        (busy),
        .bit_idx     (bit_idx),
        .cs_act      (cs_act),
        .cs_hold     (cs_hold),
        .done_pulse  (done_pulse),
        .byte_we     (eng_byte_we),
        .byte_sel    (byte_sel),
        .byte_data   (byte_data)
    );

    sfh_buf #(.WORDS(BUF_WORDS)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (reg_wr && buf_hit),
        .bus_widx  (reg_addr[2 +: WIW]),
        .bus_wdata (reg_wdata),
        .rd_widx   (reg_addr[2 +: WIW]),
        .rd_data   (buf_rdata),
        .byte_we   (eng_byte_we && user_q[USR_DIN_BIT]),
        .byte_sel  (byte_sel),
        .byte_data (byte_data),
        .bit_idx   (bit_idx),
        .bit_out   (buf_bit)
    );

    assign spi_sck  = sck_act ^ cpol;
    assign spi_mosi = busy && user_q[USR_DOUT_BIT] && buf_bit;
    assign spi_cs   = user4_q[U4_CSHI_BIT] ? cs_act : ~cs_act;

    always_comb begin
        reg_rdata = '0;
        if (buf_hit) begin
            reg_rdata = buf_rdata;
        end else begin
            case (reg_addr)
                OFS_CMD:   reg_rdata[CMD_GO_BIT] = busy;
                OFS_CTRL:  reg_rdata = ctrl_q;
                OFS_CLK:   reg_rdata[$bits(sck_cfg_t)-1:0] = clk_cfg_q;
                OFS_USER:  reg_rdata = user_q;
                OFS_USER1: reg_rdata = user1_q;
                OFS_USER4: reg_rdata = user4_q;
                OFS_STAT: begin
                    reg_rdata[STAT_MODE_BIT] = mode_q;
                    reg_rdata[STAT_DONE_BIT] = done_q;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sfh_host_chk.sv
module sfh_host_chk (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic cpol,
    input logic sck,
    input logic mosi,
    input logic cs,
    input logic cs_act,
    input logic cs_hold,
    input logic done,
    input logic srst
);

    // R11: SCK rests at its idle level whenever no transfer runs
    assert_sck_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sck == cpol));

    // R11: MOSI moves only while SCK sits at the idle level
    assert_mosi_trailing_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && (mosi != $past(mosi))) |-> (sck == cpol));

    // R8: chip select does not move during a transfer
    assert_cs_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cs));

    // R8: without hold, chip select drops with the end of the transfer
    assert_cs_release_R8: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(cs_hold)) |-> !cs_act);

    // R7: a transfer that ends normally leaves the done flag set
    assert_done_set_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(srst)) |-> done);

    // R13: after a soft reset nothing is running or selected
    assert_soft_reset_R13: assert property (@(posedge clk) disable iff (rst)
        $past(srst) |-> (!busy && !cs_act && !done));

endmodule

bind sfh_host sfh_host_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .cpol    (cpol),
    .sck     (spi_sck),
    .mosi    (spi_mosi),
    .cs      (spi_cs),
    .cs_act  (cs_act),
    .cs_hold (cs_hold),
    .done    (done_q),
    .srst    (srst)
);

// File: tb/sim_sfh_host.sv
module sim_sfh_host;

    localparam logic [6:0] A_CMD = 7'h00, A_CLK = 7'h18, A_USR = 7'h1c,
                           A_LEN = 7'h20, A_U4 = 7'h2c, A_ST = 7'h30, A_BUF = 7'h40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sck, spi_mosi, spi_cs;
    logic        spi_miso = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // flash model state
    logic       cs_on = 1'b0;
    logic       sck_idle = 1'b0;
    int         sl_bits = 0;
    int         lead_cnt = 0;
    logic [7:0] sl_rx [64];

    // SCK shape measurement
    int   act_run = 0, per_run = 0, meas_act = 0, meas_per = 0;
    logic prev_sck = 1'b0;

    always #10 clk = ~clk;

    sfh_host u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs(spi_cs)
    );

    function automatic logic [7:0] resp_byte(input int k);
        return 8'(k * 29 + 8'h5a);
    endfunction

    function automatic logic resp_bit(input int n);
        logic [7:0] b;
        b = resp_byte((n / 8) % 64);
        return b[7 - (n % 8)];
    endfunction

    function automatic logic [7:0] tx_byte(input int k, input int seed);
        return 8'(k * 13 + seed);
    endfunction

    always @(spi_cs) begin
        if (spi_cs === cs_on) begin
            sl_bits  = 0;
            spi_miso = resp_bit(0);
        end
    end

    always @(spi_sck) begin
        if (spi_cs === cs_on) begin
            if (spi_sck !== sck_idle) begin
                lead_cnt++;
                sl_rx[(sl_bits / 8) % 64][7 - (sl_bits % 8)] = spi_mosi;
            end else begin
                sl_bits++;
                spi_miso = resp_bit(sl_bits);
            end
        end
    end

    always @(negedge clk) begin
        if (spi_sck !== sck_idle) begin
            act_run++;
        end else begin
            if (act_run > 0) meas_act = act_run;
            act_run = 0;
        end
        per_run++;
        if (prev_sck === sck_idle && spi_sck !== sck_idle) begin
            meas_per = per_run;
            per_run  = 0;
        end
        prev_sck = spi_sck;
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic load_buf(input int nbytes, input int seed);
        for (int w = 0; w < (nbytes + 3) / 4; w++) begin
            wr(7'(A_BUF + 4 * w), {tx_byte(4*w+3, seed), tx_byte(4*w+2, seed),
                                   tx_byte(4*w+1, seed), tx_byte(4*w, seed)});
        end
    endtask

    task automatic start_xfer(input int nbytes, input logic [31:0] u4);
        wr(A_LEN, 32'(nbytes * 8 - 1) << 17);
        wr(A_U4, u4);
        wr(A_ST, 32'h0);
        lead_cnt = 0;
        wr(A_CMD, 32'h1 << 18);
    endtask

    task automatic wait_done();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(A_ST, s);
            if (s[4]) return;
        end
        check("R7", "done never set", 32'h0, 32'h10);
    endtask

    task automatic chk_buf_resp(input string req, input int first, input int nbytes);
        logic [31:0] d;
        for (int w = 0; w < nbytes / 4; w++) begin
            rd(7'(A_BUF + 4 * w), d);
            check(req, "buffer holds received bytes", d,
                  {resp_byte(first+4*w+3), resp_byte(first+4*w+2),
                   resp_byte(first+4*w+1), resp_byte(first+4*w)});
        end
    endtask

    task automatic chk_mosi(input string req, input int first, input int nbytes, input int seed);
        for (int k = 0; k < nbytes; k++) begin
            check(req, "byte seen on MOSI", 32'(sl_rx[first + k]), 32'(tx_byte(k, seed)));
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1", "cs idle", 32'(spi_cs), 32'h1);
        check("R1", "sck idle", 32'(spi_sck), 32'h0);
        check("R1", "mosi idle", 32'(spi_mosi), 32'h0);
        rd(A_CMD, d); check("R1", "command reg", d, 32'h0);
        rd(A_ST, d);  check("R1", "status reg", d, 32'h0);
        wr(A_CLK, 32'hFFFF_FFFF);
        rd(A_CLK, d); check("R10", "clock fields readback", d, 32'h0003_FFFF);
        wr(A_CLK, (32'd5 << 12) | (32'd2 << 6) | 32'd5);
    endtask

    task automatic t_basic();
        logic [31:0] d;
        wr(A_USR, (32'h1 << 27) | 32'h1);
        load_buf(4, 8'h11);
        start_xfer(4, 32'h0);
        rd(A_CMD, d); check("R2", "busy while shifting", d, 32'h1 << 18);
        check("R8", "cs asserted during transfer", 32'(spi_cs), 32'h0);
        wait_done();
        check("R3", "leading edge count", 32'(lead_cnt), 32'd32);
        chk_mosi("R4", 0, 4, 8'h11);
        chk_buf_resp("R5", 0, 4);
        check("R10", "active phase cycles", 32'(meas_act), 32'd3);
        check("R10", "bit period cycles", 32'(meas_per), 32'd6);
        rd(A_CMD, d); check("R2", "busy clear after end", d, 32'h0);
        check("R8", "cs released", 32'(spi_cs), 32'h1);
        wr(A_ST, 32'h10);
        rd(A_ST, d); check("R7", "writing 1 keeps done", d, 32'h10);
        wr(A_ST, 32'h0);
        rd(A_ST, d); check("R7", "writing 0 clears done", d, 32'h0);
    endtask

    task automatic t_timing();
        wr(A_CLK, (32'd7 << 12) | (32'd4 << 6) | 32'd7);
        load_buf(2, 8'h40);
        start_xfer(2, 32'h0);
        wait_done();
        check("R10", "active phase cycles, second setting", 32'(meas_act), 32'd5);
        check("R10", "bit period, second setting", 32'(meas_per), 32'd8);
        wr(A_CLK, (32'd5 << 12) | (32'd2 << 6) | 32'd5);
    endtask

    task automatic t_busy_ignore();
        load_buf(2, 8'h33);
        start_xfer(2, 32'h0);
        wr(A_LEN, 32'(63) << 17);
        wr(A_CMD, 32'h1 << 18);
        wr(A_CMD, 32'h1 << 18);
        wait_done();
        repeat (20) @(negedge clk);
        check("R12", "restart ignored, edge count", 32'(lead_cnt), 32'd16);
    endtask

    task automatic t_hold();
        load_buf(4, 8'h21);
        start_xfer(4, 32'h1 << 30);
        wait_done();
        repeat (3) @(negedge clk);
        check("R8", "cs held after chunk", 32'(spi_cs), 32'h0);
        load_buf(4, 8'h77);
        start_xfer(4, 32'h0);
        wait_done();
        check("R8", "cs released after last chunk", 32'(spi_cs), 32'h1);
        chk_mosi("R8", 4, 4, 8'h77);
        chk_buf_resp("R8", 4, 4);
    endtask

    task automatic t_cpol();
        sck_idle = 1'b1;
        wr(A_U4, 32'h1 << 29);
        @(negedge clk);
        check("R11", "idle high from user4", 32'(spi_sck), 32'h1);
        load_buf(4, 8'h52);
        start_xfer(4, 32'h1 << 29);
        wait_done();
        chk_mosi("R11", 0, 4, 8'h52);
        chk_buf_resp("R11", 0, 4);
        wr(A_U4, 32'h0);
        wr(A_USR, (32'h1 << 27) | (32'h1 << 7) | 32'h1);
        @(negedge clk);
        check("R11", "idle high from user bit 7", 32'(spi_sck), 32'h1);
        load_buf(4, 8'h63);
        start_xfer(4, 32'h0);
        wait_done();
        chk_mosi("R11", 0, 4, 8'h63);
        wr(A_USR, (32'h1 << 27) | 32'h1);
        sck_idle = 1'b0;
    endtask

    task automatic t_cspol();
        cs_on = 1'b1;
        wr(A_U4, 32'h1 << 23);
        @(negedge clk);
        check("R9", "active-high cs idles low", 32'(spi_cs), 32'h0);
        load_buf(2, 8'h19);
        start_xfer(2, 32'h1 << 23);
        @(negedge clk);
        check("R9", "active-high cs asserted", 32'(spi_cs), 32'h1);
        wait_done();
        check("R9", "active-high cs released", 32'(spi_cs), 32'h0);
        chk_mosi("R9", 0, 2, 8'h19);
        wr(A_U4, 32'h0);
        cs_on = 1'b0;
    endtask

    task automatic t_no_capture();
        logic [31:0] d;
        wr(A_USR, 32'h1 << 27);
        load_buf(4, 8'h81);
        start_xfer(4, 32'h0);
        wait_done();
        rd(A_BUF, d);
        check("R5", "buffer kept without capture", d,
              {tx_byte(3, 8'h81), tx_byte(2, 8'h81), tx_byte(1, 8'h81), tx_byte(0, 8'h81)});
    endtask

    task automatic t_no_dout();
        wr(A_USR, 32'h1);
        load_buf(4, 8'hF3);
        start_xfer(4, 32'h0);
        wait_done();
        for (int k = 0; k < 4; k++) begin
            check("R6", "MOSI low with output stage off", 32'(sl_rx[k]), 32'h0);
        end
        wr(A_USR, (32'h1 << 27) | 32'h1);
    endtask

    task automatic t_full();
        load_buf(64, 8'h07);
        start_xfer(64, 32'h0);
        wait_done();
        check("R3", "edges for 512 bits", 32'(lead_cnt), 32'd512);
        chk_mosi("R4", 0, 64, 8'h07);
        chk_buf_resp("R5", 0, 64);
    endtask

    task automatic t_soft_reset();
        logic [31:0] d;
        load_buf(8, 8'h2c);
        start_xfer(8, 32'h1 << 30);
        repeat (30) @(negedge clk);
        wr(A_ST, 32'h8000_0010);
        rd(A_CMD, d); check("R13", "busy cleared", d, 32'h0);
        rd(A_ST, d);  check("R13", "status after abort", d, 32'h0);
        check("R13", "cs released", 32'(spi_cs), 32'h1);
        check("R13", "sck idle", 32'(spi_sck), 32'h0);
        check("R13", "transfer cut short", 32'(lead_cnt < 64), 32'h1);
        load_buf(4, 8'h3d);
        start_xfer(4, 32'h0);
        wait_done();
        chk_mosi("R13", 0, 4, 8'h3d);
    endtask

    initial begin
        #(20 * 150000);
        check("R2", "watchdog expired", 32'h0, 32'h1);
        summary();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_timing();
        t_busy_ignore();
        t_hold();
        t_cpol();
        t_cspol();
        t_no_capture();
        t_no_dout();
        t_full();
        t_soft_reset();
        summary();
    end

endmodule